// File: doc/BRIEF.md
# Interlaced-to-Progressive Video Decimator

The block takes an interlaced active frame and turns it into a smaller progressive frame for a portrait display panel. The input is a pixel stream in which every line of the first field arrives before any line of the second field. The output is a sequence of reduced lines in progressive order. With the default parameters, 480 input lines of 720 pixels become 320 output lines of 240 pixels.

Reduction happens in both directions. Horizontally, one pixel in three is kept, starting with the first pixel of the line. Vertically, the two fields are interleaved into a single sequence. The sequence index is k = 2j for line j of field 1 and k = 2j+1 for line j of field 2, with j counted from 0. Every line whose k mod 3 equals 2 is dropped.

The kept lines of field 1 are reduced and stored. As each line of field 2 completes, the block plays out the stored field-1 line of the same index, followed by the just-received field-2 line, keeping whichever of the two survive the vertical drop.

Blanking must already be removed from the stream, and colour conversion happens elsewhere. A pixel is accepted on each cycle in which `in_valid` is high. `in_sof` marks the first pixel of a frame and also resynchronises the position counters.

Top module: `interlace_decimator`

## Requirements
- R1: After reset, `out_valid` and `out_sof` are low and stay low until a field-2 line has been received.
- R2: Output pixel i of a line equals input pixel 3*i of the source line, for i from 0 to OUT_W-1 (OUT_W = IN_W/3).
- R3: While the field-1 lines of the first frame after reset are being received, `out_valid` stays low.
- R4: Output lines follow progressive order. Within each line index j, the field-1 line j comes before the field-2 line j, and index j comes before index j+1.
- R5: Field-1 line j is dropped when j mod 3 = 1, and field-2 line j is dropped when j mod 3 = 2. Each frame therefore yields 4*LINES/3 output lines, where LINES is the number of lines per field.
- R6: Each output line is exactly OUT_W consecutive cycles with `out_valid` high. Two lines are always separated by at least one cycle with `out_valid` low.
- R7: `out_sof` is high for one cycle only, together with the first pixel of field-1 line 0 of each frame.
- R8: Cycles with `in_valid` low neither advance the position counters nor change the output pixel sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | With `in_valid`: first pixel of a frame (field 1, line 0, column 0) |
| in_data | input | PIX_W | Input pixel |
| out_valid | output | 1 | Line-valid: high for each pixel of an output line |
| out_sof | output | 1 | Frame-start pulse on the first output pixel of a frame |
| out_data | output | PIX_W | Output pixel |

## Verification
A wrong internal state shows up at the ports within one output line. A slipped column or decimation phase picks the wrong source pixels, which is visible in the very next emitted line. A wrong store slot or line-parity counter repeats, swaps or skips a line, which is caught at the first field-2 line it touches. The bench encodes frame, field, line and column into every pixel, so each output pixel names its own origin. A wrong line length or a merged pair breaks the framing at the falling edge of line-valid. A frame-start pulse in the wrong place shows up on the pixel where it appears.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_F1,
        SQ_GAP,
        SQ_F2
    } seq_st_t;

    typedef struct packed {
        logic first;  // pair index 0: carries frame start
        logic k1;     // field-1 line of this pair is kept
        logic k2;     // field-2 line of this pair is kept
        logic bank;   // ping-pong bank holding the field-2 line
    } pair_flags_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // interleaved index k = 2j -> dropped when k mod 3 == 2, i.e. j mod 3 == 1
    function automatic logic keep_f1(input logic [1:0] jm);
        return jm != 2'd1;
    endfunction

    // interleaved index k = 2j+1 -> dropped when j mod 3 == 2
    function automatic logic keep_f2(input logic [1:0] jm);
        return jm != 2'd2;
    endfunction

    function automatic int f1_slots(input int lpf);
        return lpf - (lpf + 1) / 3;
    endfunction

endpackage

// File: rtl/ipd_linemem.sv
module ipd_linemem #(
    parameter int PIX_W  = 16,
    parameter int OUT_W  = 240,
    parameter int DEPTH  = 160,
    parameter int SLOT_W = 8,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [COL_W-1:0]  wcol,
    input  logic [PIX_W-1:0]  wdata,
    input  logic [SLOT_W-1:0] rslot,
    input  logic [COL_W-1:0]  rcol,
    output logic [PIX_W-1:0]  rdata
);
    localparam int LINE_BITS = OUT_W * PIX_W;

    // one entry per reduced line keeps the element count at DEPTH
    logic [LINE_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wslot][wcol*PIX_W +: PIX_W] <= wdata;
        end
    end

    assign rdata = mem[rslot][rcol*PIX_W +: PIX_W];

endmodule

// File: rtl/ipd_tracker.sv
module ipd_tracker
    import ipd_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int IN_W   = 720,
    parameter int LPF    = 240,
    parameter int SLOT_W = 8,
    parameter int COL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [PIX_W-1:0]  in_data,
    output logic              f1_we,
    output logic [SLOT_W-1:0] f1_wslot,
    output logic              f2_we,
    output logic              f2_bank,
    output logic [COL_W-1:0]  wcol,
    output logic [PIX_W-1:0]  wdata,
    output logic              pair_go,
    output pair_flags_t       pair_flags,
    output logic [SLOT_W-1:0] pair_slot
);
    localparam int OUT_W    = IN_W / 3;
    localparam int F1_SLOTS = f1_slots(LPF);
    localparam int CW       = idx_w(IN_W);
    localparam int JW       = idx_w(LPF);

    logic [CW-1:0]     col,   e_col;
    logic [1:0]        hph,   e_hph;
    logic [COL_W-1:0]  ocol,  e_ocol;
    logic [JW-1:0]     j,     e_j;
    logic [1:0]        jmod,  e_jmod;
    logic              fld,   e_fld;
    logic              bank,  e_bank;
    logic [SLOT_W-1:0] wslot, e_wslot;
    logic [SLOT_W-1:0] rslot, e_rslot;
    logic              sofv, hkeep, eol, lastj, k1, k2;

    // effective position of the current pixel; a frame start forces zero
    always_comb begin
        sofv    = in_valid && in_sof;
        e_col   = sofv ? '0 : col;
        e_hph   = sofv ? '0 : hph;
        e_ocol  = sofv ? '0 : ocol;
        e_j     = sofv ? '0 : j;
        e_jmod  = sofv ? '0 : jmod;
        e_fld   = sofv ? 1'b0 : fld;
        e_bank  = sofv ? 1'b0 : bank;
        e_wslot = sofv ? '0 : wslot;
        e_rslot = sofv ? '0 : rslot;
        hkeep   = (e_hph == 2'd0);
        eol     = (e_col == CW'(IN_W - 1));
        lastj   = (e_j == JW'(LPF - 1));
        k1      = keep_f1(e_jmod);
        k2      = keep_f2(e_jmod);
    end

    assign f1_we    = in_valid && !e_fld && hkeep && k1;
    assign f2_we    = in_valid && e_fld && hkeep;
    assign f1_wslot = e_wslot;
    assign f2_bank  = e_bank;
    assign wcol     = e_ocol;
    assign wdata    = in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0; hph <= '0; ocol <= '0; j <= '0; jmod <= '0;
            fld <= 1'b0; bank <= 1'b0; wslot <= '0; rslot <= '0;
            pair_go <= 1'b0; pair_flags <= '0; pair_slot <= '0;
        end else begin
            pair_go <= 1'b0;
            if (in_valid) begin
                col   <= e_col + 1'b1;
                hph   <= (e_hph == 2'd2) ? 2'd0 : e_hph + 2'd1;
                ocol  <= e_ocol + COL_W'(hkeep);
                j     <= e_j;
                jmod  <= e_jmod;
                fld   <= e_fld;
                bank  <= e_bank;
                wslot <= e_wslot;
                rslot <= e_rslot;
                if (eol) begin
                    col  <= '0;
                    hph  <= '0;
                    ocol <= '0;
                    if (e_fld) begin
                        pair_go          <= 1'b1;
                        pair_flags.first <= (e_j == '0);
                        pair_flags.k1    <= k1;
                        pair_flags.k2    <= k2;
                        pair_flags.bank  <= e_bank;
                        pair_slot        <= e_rslot;
                        bank             <= ~e_bank;
                        if (k1) rslot <= e_rslot + 1'b1;
                    end else if (k1) begin
                        wslot <= e_wslot + 1'b1;
                    end
                    if (lastj) begin
                        j    <= '0;
                        jmod <= '0;
                        fld  <= ~e_fld;
                        if (e_fld) begin
                            wslot <= '0;
                        end else begin
                            rslot <= '0;
                            bank  <= 1'b0;
                        end
                    end else begin
                        j    <= e_j + 1'b1;
                        jmod <= (e_jmod == 2'd2) ? 2'd0 : e_jmod + 2'd1;
                    end
                end
            end
        end
    end

    // R5: a stored field-1 line never lands outside the line store
    p_store_slot_r5: assert property (@(posedge clk) disable iff (rst)
        f1_we |-> (int'(f1_wslot) < F1_SLOTS));

    // R2: the reduced column index stays inside an output line
    p_wcol_range_r2: assert property (@(posedge clk) disable iff (rst)
        (f1_we || f2_we) |-> (int'(wcol) < OUT_W));

endmodule

// File: rtl/ipd_sequencer.sv
module ipd_sequencer
    import ipd_pkg::*;
#(
    parameter int PIX_W    = 16,
    parameter int OUT_W    = 240,
    parameter int F1_SLOTS = 160,
    parameter int SLOT_W   = 8,
    parameter int COL_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pair_go,
    input  pair_flags_t       pair_flags,
    input  logic [SLOT_W-1:0] pair_slot,
    output logic [SLOT_W-1:0] f1_rslot,
    output logic              f2_rbank,
    output logic [COL_W-1:0]  rcol,
    input  logic [PIX_W-1:0]  f1_rdata,
    input  logic [PIX_W-1:0]  f2_rdata,
    output logic              out_valid,
    output logic              out_sof,
    output logic [PIX_W-1:0]  out_data
);
    seq_st_t           st;
    logic [COL_W-1:0]  col;
    pair_flags_t       flg;
    logic [SLOT_W-1:0] slot;
    logic              emit, last_col;

    assign f1_rslot = slot;
    assign f2_rbank = flg.bank;
    assign rcol     = col;
    assign emit     = (st == SQ_F1) || (st == SQ_F2);
    assign last_col = (col == COL_W'(OUT_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            col       <= '0;
            flg       <= '0;
            slot      <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && flg.first && (col == '0);
            out_data  <= (st == SQ_F1) ? f1_rdata : f2_rdata;
            case (st)
                SQ_IDLE: begin
                    if (pair_go) begin
                        flg  <= pair_flags;
                        slot <= pair_slot;
                        col  <= '0;
                        st   <= pair_flags.k1 ? SQ_F1 : SQ_F2;
                    end
                end
                SQ_F1: begin
                    col <= col + 1'b1;
                    if (last_col) begin
                        col       <= '0;
                        flg.first <= 1'b0;
                        st        <= flg.k2 ? SQ_GAP : SQ_IDLE;
                    end
                end
                SQ_GAP: st <= SQ_F2;
                SQ_F2: begin
                    col <= col + 1'b1;
                    if (last_col) begin
                        col       <= '0;
                        flg.first <= 1'b0;
                        st        <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R6: a new pair never arrives while the previous one is still playing out
    p_pair_idle_r6: assert property (@(posedge clk) disable iff (rst)
        pair_go |-> (st == SQ_IDLE));

    // R5: playback reads only written field-1 slots
    p_read_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_F1) |-> (int'(slot) < F1_SLOTS));

endmodule

// File: rtl/interlace_decimator.sv
module interlace_decimator
    import ipd_pkg::*;
#(
    parameter int PIX_W = 16,
    parameter int IN_W  = 720,
    parameter int LPF   = 240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [PIX_W-1:0] in_data,
    output logic             out_valid,
    output logic             out_sof,
    output logic [PIX_W-1:0] out_data
);
    localparam int OUT_W    = IN_W / 3;
    localparam int F1_SLOTS = f1_slots(LPF);
    localparam int SW       = idx_w(F1_SLOTS + 1);
    localparam int OW       = idx_w(OUT_W);

    logic              f1_we, f2_we, f2_wbank, pair_go, f2_rbank;
    logic [SW-1:0]     f1_wslot, pair_slot, f1_rslot;
    logic [OW-1:0]     wcol, rcol;
    logic [PIX_W-1:0]  wdata, f1_rdata, f2_rdata;
    pair_flags_t       pair_flags;

    ipd_tracker #(
        .PIX_W(PIX_W), .IN_W(IN_W), .LPF(LPF), .SLOT_W(SW), .COL_W(OW)
    ) u_trk (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .f1_we(f1_we), .f1_wslot(f1_wslot),
        .f2_we(f2_we), .f2_bank(f2_wbank),
        .wcol(wcol), .wdata(wdata),
        .pair_go(pair_go), .pair_flags(pair_flags), .pair_slot(pair_slot)
    );

    ipd_linemem #(
        .PIX_W(PIX_W), .OUT_W(OUT_W), .DEPTH(F1_SLOTS), .SLOT_W(SW), .COL_W(OW)
    ) u_f1_store (
        .clk(clk), .we(f1_we), .wslot(f1_wslot), .wcol(wcol), .wdata(wdata),
        .rslot(f1_rslot), .rcol(rcol), .rdata(f1_rdata)
    );

    ipd_linemem #(
        .PIX_W(PIX_W), .OUT_W(OUT_W), .DEPTH(2), .SLOT_W(1), .COL_W(OW)
    ) u_f2_pingpong (
        .clk(clk), .we(f2_we), .wslot(f2_wbank), .wcol(wcol), .wdata(wdata),
        .rslot(f2_rbank), .rcol(rcol), .rdata(f2_rdata)
    );

    ipd_sequencer #(
        .PIX_W(PIX_W), .OUT_W(OUT_W), .F1_SLOTS(F1_SLOTS), .SLOT_W(SW), .COL_W(OW)
    ) u_seq (
        .clk(clk), .rst(rst),
        .pair_go(pair_go), .pair_flags(pair_flags), .pair_slot(pair_slot),
        .f1_rslot(f1_rslot), .f2_rbank(f2_rbank), .rcol(rcol),
        .f1_rdata(f1_rdata), .f2_rdata(f2_rdata),
        .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
    );

    // run length of line-valid, used only by the framing checks below
    logic [OW:0] vrun;
    always_ff @(posedge clk) begin
        if (rst) vrun <= '0;
        else     vrun <= out_valid ? vrun + 1'b1 : '0;
    end

    // R6: every line ends after exactly OUT_W valid cycles
    p_line_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (vrun == (OW+1)'(OUT_W)));

    // R7: frame start sits on a valid pixel and lasts one cycle
    p_sof_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);
    p_sof_single_r7: assert property (@(posedge clk) disable iff (rst)
        out_sof |=> !out_sof);

endmodule

// File: tb/tb_interlace_decimator.sv
`timescale 1ns/1ps
module tb_interlace_decimator;
    localparam int PIX_W  = 16;
    localparam int IN_W   = 12;
    localparam int LPF    = 6;
    localparam int OUT_W  = IN_W / 3;
    localparam int NFR    = 4;
    localparam int MAXL   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic [PIX_W-1:0] in_data = '0;
    logic out_valid, out_sof;
    logic [PIX_W-1:0] out_data;

    always #2.5 clk = ~clk;

    interlace_decimator #(.PIX_W(PIX_W), .IN_W(IN_W), .LPF(LPF)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_data(out_data)
    );

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    int efr [MAXL];
    int efld[MAXL];
    int ej  [MAXL];
    int nexp = 0;
    int li = 0;
    int pcol = 0;
    bit prev_v = 1'b0;
    bit in_first_f1 = 1'b0;
    int r3_bad = 0;

    function automatic logic [PIX_W-1:0] pcode(input int fr, input int fld,
                                               input int j, input int c);
        return PIX_W'((fr << 13) | (fld << 12) | (j << 6) | c);
    endfunction

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (line %0d col %0d)",
                     req, act, exp, li, pcol);
        end
    endtask

    task automatic put_px(input logic [PIX_W-1:0] d, input logic s, input int stall);
        while (int'($urandom % 100) < stall) begin
            in_valid = 1'b0; in_sof = 1'b0;
            @(posedge clk); #1;
        end
        in_valid = 1'b1; in_data = d; in_sof = s;
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_frame(input int fr, input int stall);
        for (int fld = 0; fld < 2; fld++) begin
            if (fr == 0) in_first_f1 = (fld == 0);
            for (int j = 0; j < LPF; j++)
                for (int c = 0; c < IN_W; c++)
                    put_px(pcode(fr, fld, j, c), (fld == 0 && j == 0 && c == 0), stall);
        end
        in_first_f1 = 1'b0;
    endtask

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (in_first_f1 && out_valid) r3_bad++;
            if (out_valid) begin
                if (li >= nexp) begin
                    check(1'b0, "R5 extra line", int'(out_data), 0);
                end else begin
                    check(out_data == pcode(efr[li], efld[li], ej[li], pcol * 3),
                          "R2/R4/R8 pixel", int'(out_data),
                          int'(pcode(efr[li], efld[li], ej[li], pcol * 3)));
                    check(out_sof == (pcol == 0 && efld[li] == 0 && ej[li] == 0),
                          "R7 frame start", int'(out_sof),
                          int'(pcol == 0 && efld[li] == 0 && ej[li] == 0));
                end
                pcol++;
            end else if (prev_v) begin
                check(pcol == OUT_W, "R6 line length", pcol, OUT_W);
                li++;
                pcol = 0;
            end
            prev_v = out_valid;
        end
    end

    initial begin
        void'($urandom(32'd4177));
        // expected progressive line list (R4, R5)
        for (int fr = 0; fr < NFR; fr++)
            for (int j = 0; j < LPF; j++) begin
                if (j % 3 != 1) begin
                    efr[nexp] = fr; efld[nexp] = 0; ej[nexp] = j; nexp++;
                end
                if (j % 3 != 2) begin
                    efr[nexp] = fr; efld[nexp] = 1; ej[nexp] = j; nexp++;
                end
            end

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_sof == 1'b0, "R1 reset sof", int'(out_sof), 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);

        send_frame(0, 0);    // directed: continuous stream
        send_frame(1, 30);   // random idle cycles
        send_frame(2, 70);   // heavy idle cycles
        send_frame(3, 0);    // back to continuous right after stalls
        repeat (40) @(posedge clk);
        @(negedge clk);

        check(r3_bad == 0, "R3 quiet during field 1", r3_bad, 0);
        check(li == nexp, "R5 line count", li, nexp);
        check(nexp == NFR * 4 * LPF / 3, "R5 lines per frame", nexp, NFR * 4 * LPF / 3);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule